// File: doc/BRIEF.md
# Three-Phase Grid Scanner with Dimming PWM

This block drives the time-multiplexed grids and segments of a three-grid fluorescent display. A latched display image of three segment groups is held at its input. The block walks through three grid slots in turn. In each slot it lights one grid, or in universal mode a pair of grids, and gates the matching segment group onto the segment outputs. The light stays on only for the first part of the slot, and a dimming code sets how long that part is.

Time is counted in steps. A step is `STEP_DIV` pulses of the tick enable, which is one pulse per oscillator period. A slot is `2**SLOT_W` steps long, so a full display cycle is three slots. The dimming code gives the on-time of each slot in steps. It is clamped so that at least `BLANK` dark steps always follow a window. The dimming code, the image and the mode are all captured at the first step of each slot. A change on these inputs therefore never cuts short or stretches a window that is already running.

Top module: `grid_scan_pwm`

## Requirements
- R1: Synchronous reset clears the outputs and the captured dimming code to zero. `grid_o` and `seg_o` are therefore all zero in the cycle after reset and for the whole first slot after reset is released.
- R2: A step advances on every `STEP_DIV`-th clock that has `tick_i` high. A slot is `2**SLOT_W` steps. The phase advances once per slot in the cycle 0, 1, 2, 0. While `tick_i` stays low, neither output changes.
- R3: In a slot, the active grid pattern is driven during steps 0 to L-1 and `grid_o` is zero for the rest of the slot. L is the captured dimming code after clamping, so a code of zero keeps every grid off.
- R4: L equals the code when the code is at most `2**SLOT_W - BLANK`. Any larger code gives L = `2**SLOT_W - BLANK`. At default size, 0x3F8 gives 1016 on-steps, 0x1FF gives 511 and 0x3FF gives 1016.
- R5: With `mode_i` low, the lit pattern on `grid_o` is 3'b001 in phase 0, 3'b010 in phase 1 and 3'b100 in phase 2. Bit 0 is grid 1.
- R6: With `mode_i` high, phase 2 lights 3'b011, so grids 1 and 2 are on together. `grid_o[2]` is never set in this mode.
- R7: While a grid is lit, `seg_o` shows one slice of `img_i`. Phase 0 shows `img_i[SEG_N-1:0]`, phase 1 shows `img_i[2*SEG_N-1:SEG_N]` and phase 2 shows `img_i[3*SEG_N-1:2*SEG_N]`.
- R8: `seg_o` is all zero whenever `grid_o` is all zero.
- R9: Between the end of one lit window and the start of the next, at least `BLANK` steps pass with every grid off.
- R10: `code_i`, `img_i` and `mode_i` are sampled only at the step that starts a slot. Changing them during a slot has no effect on the outputs until the next slot begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oscillator-period enable |
| mode_i | input | 1 | 0: three single grids; 1: third phase lights grids 1 and 2 |
| code_i | input | SLOT_W | Dimming code, on-steps per slot |
| img_i | input | 3*SEG_N | Latched display image, three segment groups |
| grid_o | output | 3 | Grid enables, bit 0 is grid 1 |
| seg_o | output | SEG_N | Segment enables |

## Verification
Both outputs are registered. The value seen after a clock edge is computed from the step, phase and captured inputs as they stood just before that edge. A tick therefore shows up on the outputs one clock after the edge that counts it. The bench keeps its own tick count and its own slot-start snapshots of code, image and mode, and keeps a one-edge-delayed copy of both. At each falling edge it compares the outputs against the values computed from that delayed copy. The full-size instance is checked by totalling lit cycles over a fixed window of three slots. That total must equal two windows of L steps times `STEP_DIV`, because the first slot after reset is always dark.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;
  localparam int N_PHASE = 3;

  typedef enum logic [1:0] {PH_A = 2'd0, PH_B = 2'd1, PH_C = 2'd2} phase_e;

  // lit grid pattern for a phase; bit 0 is grid 1
  function automatic logic [2:0] grid_pattern(input phase_e ph, input logic uni);
    case (ph)
      PH_A:    grid_pattern = 3'b001;
      PH_B:    grid_pattern = 3'b010;
      PH_C:    grid_pattern = uni ? 3'b011 : 3'b100;
      default: grid_pattern = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/grid_step_timer.sv
module grid_step_timer #(
  parameter int STEP_DIV = 4,
  parameter int SLOT_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] step_o,
  output logic              slot_end_o
);
  localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [SLOT_W-1:0] STEP_LAST = {SLOT_W{1'b1}};

  logic step_adv;

  generate
    if (STEP_DIV > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst)          pre_q <= '0;
        else if (tick_i)  pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
      assign step_adv = tick_i && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign step_adv = tick_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           step_o <= '0;
    else if (step_adv) step_o <= step_o + 1'b1;
  end

  assign slot_end_o = step_adv && (step_o == STEP_LAST);
endmodule

// File: rtl/grid_phase_seq.sv
module grid_phase_seq
  import grid_scan_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int IMG_W  = 111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_end_i,
  input  logic              mode_i,
  input  logic [SLOT_W-1:0] code_i,
  input  logic [IMG_W-1:0]  img_i,
  output phase_e            phase_o,
  output logic              mode_q,
  output logic [SLOT_W-1:0] code_q,
  output logic [IMG_W-1:0]  img_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= PH_A;
      mode_q  <= 1'b0;
      code_q  <= '0;
      img_q   <= '0;
    end else if (slot_end_i) begin
      phase_o <= (phase_o == PH_C) ? PH_A : phase_e'(phase_o + 2'd1);
      mode_q  <= mode_i;
      code_q  <= code_i;
      img_q   <= img_i;
    end
  end
endmodule

// File: rtl/grid_drive.sv
module grid_drive
  import grid_scan_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int SEG_N  = 37,
  parameter int BLANK  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_W-1:0]    step_i,
  input  phase_e               phase_i,
  input  logic                 mode_i,
  input  logic [SLOT_W-1:0]    code_i,
  input  logic [3*SEG_N-1:0]   img_i,
  output logic [2:0]           grid_o,
  output logic [SEG_N-1:0]     seg_o
);
  localparam logic [SLOT_W-1:0] MAX_ON = SLOT_W'((1 << SLOT_W) - BLANK);

  logic [SEG_N-1:0]  slice [4];
  logic [SLOT_W-1:0] on_len;
  logic              lit;

  generate
    for (genvar p = 0; p < N_PHASE; p++) begin : g_slice
      assign slice[p] = img_i[p*SEG_N +: SEG_N];
    end
  endgenerate
  assign slice[3] = '0;

  assign on_len = (code_i > MAX_ON) ? MAX_ON : code_i;
  assign lit    = step_i < on_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_o <= '0;
      seg_o  <= '0;
    end else begin
      grid_o <= lit ? grid_pattern(phase_i, mode_i) : 3'b000;
      seg_o  <= lit ? slice[phase_i] : '0;
    end
  end
endmodule

// File: rtl/grid_scan_pwm.sv
module grid_scan_pwm
  import grid_scan_pkg::*;
#(
  parameter int STEP_DIV = 4,
  parameter int SLOT_W   = 10,
  parameter int BLANK    = 8,
  parameter int SEG_N    = 37,
  localparam int IMG_W   = N_PHASE * SEG_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              mode_i,
  input  logic [SLOT_W-1:0] code_i,
  input  logic [IMG_W-1:0]  img_i,
  output logic [2:0]        grid_o,
  output logic [SEG_N-1:0]  seg_o
);
  logic [SLOT_W-1:0] step;
  logic              slot_end;
  phase_e            phase;
  logic              mode_q;
  logic [SLOT_W-1:0] code_q;
  logic [IMG_W-1:0]  img_q;

  grid_step_timer #(.STEP_DIV(STEP_DIV), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .step_o(step), .slot_end_o(slot_end)
  );

  grid_phase_seq #(.SLOT_W(SLOT_W), .IMG_W(IMG_W)) u_seq (
    .clk(clk), .rst(rst), .slot_end_i(slot_end),
    .mode_i(mode_i), .code_i(code_i), .img_i(img_i),
    .phase_o(phase), .mode_q(mode_q), .code_q(code_q), .img_q(img_q)
  );

  grid_drive #(.SLOT_W(SLOT_W), .SEG_N(SEG_N), .BLANK(BLANK)) u_drive (
    .clk(clk), .rst(rst), .step_i(step), .phase_i(phase),
    .mode_i(mode_q), .code_i(code_q), .img_i(img_q),
    .grid_o(grid_o), .seg_o(seg_o)
  );
endmodule

// File: rtl/grid_scan_pwm_chk.sv
module grid_scan_pwm_chk #(
  parameter int STEP_DIV = 4,
  parameter int BLANK    = 8,
  parameter int SEG_N    = 37
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic [2:0]       grid_o,
  input logic [SEG_N-1:0] seg_o
);
  localparam int GAP_W = 20;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(BLANK * STEP_DIV - 1);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (|grid_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (tick_i && !(&gap_q)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  a_r1_reset_dark: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grid_o == 3'b000 && seg_o == '0));

  // R5 R6
  a_r6_grid_legal: assert property (@(posedge clk) disable iff (rst)
    grid_o inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b011});

  // R8
  a_r8_seg_dark: assert property (@(posedge clk) disable iff (rst)
    (grid_o == 3'b000) |-> (seg_o == '0));

  // R9
  a_r9_blank_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(|grid_o) && seen_q) |-> (gap_q >= GAP_MIN));

  // R2
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(tick_i, 2)) |-> ($stable(grid_o) && $stable(seg_o)));
endmodule

bind grid_scan_pwm grid_scan_pwm_chk #(
  .STEP_DIV(STEP_DIV), .BLANK(BLANK), .SEG_N(SEG_N)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .grid_o(grid_o), .seg_o(seg_o)
);

// File: tb/grid_scan_pwm_bench.sv
module grid_scan_pwm_bench;
  localparam int SW = 5, DIV = 2, BL = 8, SN = 4, IW = 3 * SN;
  localparam int SLOT = 1 << SW, MAXON = SLOT - BL, CYC = DIV * SLOT;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, tick = 1'b0, mode = 1'b0;
  logic [SW-1:0] code = '0;
  logic [IW-1:0] img = '0;
  logic [2:0]    grid;
  logic [SN-1:0] seg;

  logic          rstf = 1'b1;
  logic [9:0]    codef = '0;
  logic [2:0]    gridf;
  logic [36:0]   segf;

  int vec = 0, bad = 0;
  logic chk_en = 1'b0;

  grid_scan_pwm #(.STEP_DIV(DIV), .SLOT_W(SW), .BLANK(BL), .SEG_N(SN)) u_grid_scan_pwm (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .code_i(code), .img_i(img),
    .grid_o(grid), .seg_o(seg)
  );

  grid_scan_pwm u_grid_scan_pwm_full (
    .clk(clk), .rst(rstf), .tick_i(1'b1), .mode_i(1'b0), .code_i(codef), .img_i({111{1'b1}}),
    .grid_o(gridf), .seg_o(segf)
  );

  // reference model: tick count plus slot-start snapshots, and a copy from one edge earlier
  int m_t = 0, s_t = 0;
  logic [SW-1:0] m_code = '0, s_code = '0;
  logic [IW-1:0] m_img = '0, s_img = '0;
  logic          m_mode = 1'b0, s_mode = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_t <= 0; m_code <= '0; m_img <= '0; m_mode <= 1'b0;
      s_t <= 0; s_code <= '0; s_img <= '0; s_mode <= 1'b0;
    end else begin
      s_t <= m_t; s_code <= m_code; s_img <= m_img; s_mode <= m_mode;
      if (tick) begin
        m_t <= m_t + 1;
        if ((m_t + 1) % CYC == 0) begin  // R10: capture only at slot start
          m_code <= code; m_img <= img; m_mode <= mode;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      int st, ph, len;
      logic [2:0] eg;
      logic [SN-1:0] es;
      st  = (s_t / DIV) % SLOT;               // R2
      ph  = (s_t / CYC) % 3;
      len = (int'(s_code) > MAXON) ? MAXON : int'(s_code);  // R4
      if (st < len) begin                     // R3, R9 through the clamp
        eg = (ph == 0) ? 3'b001 : (ph == 1) ? 3'b010 : (s_mode ? 3'b011 : 3'b100);
        es = s_img[ph*SN +: SN];              // R7
      end else begin
        eg = 3'b000;
        es = '0;                              // R8
      end
      vec++;
      if (grid !== eg) begin
        bad++;
        if (eg == 3'b000)      $display("FAIL R3 grid dark: got %b exp %b (t=%0d)", grid, eg, s_t);
        else if (eg == 3'b011) $display("FAIL R6 grid pair: got %b exp %b (t=%0d)", grid, eg, s_t);
        else                   $display("FAIL R5 grid seq: got %b exp %b (t=%0d)", grid, eg, s_t);
      end
      vec++;
      if (seg !== es) begin
        bad++;
        if (eg == 3'b000) $display("FAIL R8 seg dark: got %h exp %h (t=%0d)", seg, es, s_t);
        else              $display("FAIL R7 seg slice: got %h exp %h (t=%0d)", seg, es, s_t);
      end
    end
  end

  task automatic full_run(input logic [9:0] c, input int exp_steps);
    int lit;
    lit = 0;
    @(negedge clk); rstf = 1'b1; codef = c;
    repeat (2) @(negedge clk);
    rstf = 1'b0;
    repeat (3 * 4 * 1024) begin
      @(negedge clk);
      if (|gridf) lit++;
    end
    vec++;
    if (lit != 2 * 4 * exp_steps) begin
      bad++;
      $display("FAIL R4 code %h lit cycles: got %0d exp %0d", c, lit, 2 * 4 * exp_steps);
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs dark under reset
    vec++;
    if (grid !== 3'b000 || seg !== '0) begin
      bad++;
      $display("FAIL R1 reset: got %b/%h exp 000/0", grid, seg);
    end
    chk_en = 1'b1;
    code = 5'd20; img = 12'hABC;   // R1: ignored for the first slot after release
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < SLOT; c++) begin
        mode = m[0];
        code = SW'(c);
        img  = IW'((c * 613 + m * 1877 + 91) % 4096);
        for (int k = 0; k < 3 * CYC + 17; k++) begin
          tick = (c % 4 == 3) ? (k % 3 != 0) : 1'b1;   // R2: gated ticks
          @(negedge clk);
        end
      end
    end
    tick = 1'b0;
    repeat (20) @(negedge clk);   // R2: frozen with no ticks
    chk_en = 1'b0;
    full_run(10'h3F8, 1016);   // R4
    full_run(10'h1FF, 511);    // R4
    full_run(10'h3FF, 1016);   // R4 clamp
    full_run(10'h000, 0);      // R3 zero code
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule